// File: doc/BRIEF.md
# Redundant Thread Load Value Queue

This block feeds identical load inputs to two redundant copies of one program that run as a leading and a trailing hardware thread. The roles are fixed by wiring: only the leading thread's loads reach the data memory. Each address and the word read for it are written into a first-in first-out queue in program order. Loads from the trailing thread never reach memory. Each trailing load takes the oldest queued word and has its address compared with the address held in that entry.

The leading thread may run ahead of the trailing thread by as many loads as the queue holds. Both copies always see the same value for the same load, even if another agent writes memory between the two accesses. When the queue cannot take another entry, leading loads stall. Trailing loads stall while the queue is empty. An address that disagrees with the entry it pops raises a single-cycle fault pulse.

Top module: `load_replica_queue`

## Requirements
- R1: A leading load is accepted in the cycle where `lead_req_valid_i` and `lead_req_ready_o` are both high. In that cycle `mem_req_o` is high and `mem_addr_o` carries the load address. The memory returns the word on `mem_rdata_i` one cycle later. In that later cycle `lead_rsp_valid_o` is high and `lead_rsp_data_o` carries the word.
- R2: `mem_req_o` is never high unless a leading load is accepted. Trailing loads never cause a memory access.
- R3: Trailing loads take entries in strict program order. The n-th accepted trailing load returns, on `trail_rsp_data_o`, the word read by the n-th accepted leading load.
- R4: A trailing load returns the word read by its leading load, even if memory at that address has been rewritten since then.
- R5: A trailing load is accepted when `trail_req_valid_i` and `trail_req_ready_o` are both high. If its address differs from the address stored with the entry, `fault_o` is high for exactly the next cycle. If the addresses are equal, `fault_o` stays low.
- R6: Up to DEPTH (default 16) leading loads may be outstanding. This count includes a load still waiting for its memory word. Once DEPTH loads are outstanding, `lead_req_ready_o` stays low until a trailing load frees an entry.
- R7: `trail_req_ready_o` is low while the queue holds no entry. A trailing request made then removes nothing and raises no fault.
- R8: After the active-low asynchronous reset, the queue is empty, `lead_req_ready_o` is high, `trail_req_ready_o` is low, and `fault_o` and `mem_req_o` are low.
- R9: A leading load and a trailing load may be accepted in the same cycle. Order and values are kept across back-to-back traffic in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lead_req_valid_i | input | 1 | Leading thread load request |
| lead_req_ready_o | output | 1 | Leading load can be accepted |
| lead_req_addr_i | input | 32 | Leading load address |
| lead_rsp_valid_o | output | 1 | Leading load word valid |
| lead_rsp_data_o | output | 32 | Word returned to the leading thread |
| mem_req_o | output | 1 | Memory read strobe |
| mem_addr_o | output | 32 | Memory read address |
| mem_rdata_i | input | 32 | Memory word, one cycle after the strobe |
| trail_req_valid_i | input | 1 | Trailing thread load request |
| trail_req_ready_o | output | 1 | An entry is available for the trailing thread |
| trail_req_addr_i | input | 32 | Trailing load address, checked against the entry |
| trail_rsp_data_o | output | 32 | Word handed to the trailing thread |
| fault_o | output | 1 | One-cycle pulse on an address mismatch |

## Verification
The bench rewrites memory after a leading load. A design that read memory for the trailing thread would then return the new word instead of the replicated one. It keeps leading requests asserted until the queue fills. If the pending memory read were not counted, one extra load would be accepted and the oldest entry overwritten. Trailing requests against an empty queue and mismatching addresses are also driven. A wrong empty check would pop garbage. A fault held too long, or raised on a match, would show up on the cycle after the pop. Simultaneous push and pop traffic checks that the occupancy count and the pointer wrap keep the order intact.

// File: rtl/lrq_pkg.sv
package lrq_pkg;
  localparam int unsigned LRQ_ADDR_W = 32;
  localparam int unsigned LRQ_DATA_W = 32;

  typedef logic [LRQ_ADDR_W-1:0] lrq_addr_t;
  typedef logic [LRQ_DATA_W-1:0] lrq_data_t;

  typedef struct packed {
    lrq_addr_t addr;
    lrq_data_t data;
  } lrq_entry_t;
endpackage

// File: rtl/lrq_lead_issue.sv
module lrq_lead_issue
  import lrq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  lrq_addr_t        req_addr_i,
  input  logic [CNT_W-1:0] occ_i,
  input  lrq_data_t        mem_rdata_i,
  output logic             req_ready_o,
  output logic             mem_req_o,
  output lrq_addr_t        mem_addr_o,
  output logic             rsp_valid_o,
  output lrq_data_t        rsp_data_o,
  output logic             push_o,
  output lrq_entry_t       push_entry_o
);
  logic       pending_q;
  lrq_addr_t  addr_q;
  logic [CNT_W:0] used;
  logic       fire;

  // slot reserved for the read still in flight
  assign used        = {1'b0, occ_i} + {{CNT_W{1'b0}}, pending_q};
  assign req_ready_o = used < (CNT_W + 1)'(DEPTH);
  assign fire        = req_valid_i & req_ready_o;

  assign mem_req_o  = fire;
  assign mem_addr_o = req_addr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_q <= 1'b0;
      addr_q    <= '0;
    end else begin
      pending_q <= fire;
      if (fire) addr_q <= req_addr_i;
    end
  end

  assign rsp_valid_o  = pending_q;
  assign rsp_data_o   = mem_rdata_i;
  assign push_o       = pending_q;
  assign push_entry_o = '{addr: addr_q, data: mem_rdata_i};
endmodule

// File: rtl/lrq_store.sv
module lrq_store
  import lrq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  lrq_entry_t       push_entry_i,
  input  logic             pop_i,
  output lrq_entry_t       head_o,
  output logic [CNT_W-1:0] count_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  lrq_entry_t       slots_q [DEPTH];
  logic [PTR_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] count_q;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i) slots_q[tail_q] <= push_entry_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      if (push_i) tail_q <= bump(tail_q);
      if (pop_i)  head_q <= bump(head_q);
      unique case ({push_i, pop_i})
        2'b10:   count_q <= count_q + CNT_W'(1);
        2'b01:   count_q <= count_q - CNT_W'(1);
        default: count_q <= count_q;
      endcase
    end
  end

  assign head_o  = slots_q[head_q];
  assign count_o = count_q;
endmodule

// File: rtl/lrq_trail_check.sv
module lrq_trail_check
  import lrq_pkg::*;
#(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  lrq_addr_t        req_addr_i,
  input  lrq_entry_t       head_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             req_ready_o,
  output logic             pop_o,
  output lrq_data_t        rsp_data_o,
  output logic             fault_o
);
  logic fault_q;

  assign req_ready_o = count_i != '0;
  assign pop_o       = req_valid_i & req_ready_o;
  assign rsp_data_o  = head_i.data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fault_q <= 1'b0;
    else         fault_q <= pop_o && (req_addr_i != head_i.addr);
  end

  assign fault_o = fault_q;
endmodule

// File: rtl/load_replica_queue.sv
module load_replica_queue
  import lrq_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  lead_req_valid_i,
  output logic                  lead_req_ready_o,
  input  logic [LRQ_ADDR_W-1:0] lead_req_addr_i,
  output logic                  lead_rsp_valid_o,
  output logic [LRQ_DATA_W-1:0] lead_rsp_data_o,
  output logic                  mem_req_o,
  output logic [LRQ_ADDR_W-1:0] mem_addr_o,
  input  logic [LRQ_DATA_W-1:0] mem_rdata_i,
  input  logic                  trail_req_valid_i,
  output logic                  trail_req_ready_o,
  input  logic [LRQ_ADDR_W-1:0] trail_req_addr_i,
  output logic [LRQ_DATA_W-1:0] trail_rsp_data_o,
  output logic                  fault_o
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic             push, pop;
  lrq_entry_t       push_entry, head;
  logic [CNT_W-1:0] count;

  lrq_lead_issue #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_lead (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (lead_req_valid_i),
    .req_addr_i   (lead_req_addr_i),
    .occ_i        (count),
    .mem_rdata_i  (mem_rdata_i),
    .req_ready_o  (lead_req_ready_o),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .rsp_valid_o  (lead_rsp_valid_o),
    .rsp_data_o   (lead_rsp_data_o),
    .push_o       (push),
    .push_entry_o (push_entry)
  );

  lrq_store #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_store (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .push_i       (push),
    .push_entry_i (push_entry),
    .pop_i        (pop),
    .head_o       (head),
    .count_o      (count)
  );

  lrq_trail_check #(.CNT_W(CNT_W)) u_trail (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (trail_req_valid_i),
    .req_addr_i  (trail_req_addr_i),
    .head_i      (head),
    .count_i     (count),
    .req_ready_o (trail_req_ready_o),
    .pop_o       (pop),
    .rsp_data_o  (trail_rsp_data_o),
    .fault_o     (fault_o)
  );
endmodule

// File: rtl/lrq_checker.sv
module lrq_checker #(
  parameter int unsigned DEPTH = 16
) (
  input logic clk_i,
  input logic rst_ni,
  input logic lead_req_valid_i,
  input logic lead_req_ready_o,
  input logic lead_rsp_valid_o,
  input logic mem_req_o,
  input logic trail_req_valid_i,
  input logic trail_req_ready_o,
  input logic fault_o
);
  localparam int unsigned CW = $clog2(DEPTH + 1) + 1;

  logic [CW-1:0] occ_q, held_q;
  logic lead_acc, trail_acc;

  assign lead_acc  = lead_req_valid_i & lead_req_ready_o;
  assign trail_acc = trail_req_valid_i & trail_req_ready_o;

  // independent occupancy: outstanding loads and committed entries
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      occ_q  <= '0;
      held_q <= '0;
    end else begin
      occ_q  <= occ_q + CW'(lead_acc) - CW'(trail_acc);
      held_q <= held_q + CW'(lead_rsp_valid_o) - CW'(trail_acc);
    end
  end

  a_r2_mem_only_lead: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> lead_acc);

  a_r1_rsp_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lead_rsp_valid_o |-> $past(mem_req_o));

  a_r6_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ_q <= CW'(DEPTH));

  a_r6_stall_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (occ_q == CW'(DEPTH)) |-> !lead_req_ready_o);

  a_r7_no_pop_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (held_q == '0) |-> !trail_req_ready_o);

  a_r5_fault_after_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> $past(trail_acc));
endmodule

bind load_replica_queue lrq_checker #(.DEPTH(DEPTH)) u_lrq_checker (
  .clk_i             (clk_i),
  .rst_ni            (rst_ni),
  .lead_req_valid_i  (lead_req_valid_i),
  .lead_req_ready_o  (lead_req_ready_o),
  .lead_rsp_valid_o  (lead_rsp_valid_o),
  .mem_req_o         (mem_req_o),
  .trail_req_valid_i (trail_req_valid_i),
  .trail_req_ready_o (trail_req_ready_o),
  .fault_o           (fault_o)
);

// File: tb/load_replica_queue_test.sv
module load_replica_queue_test;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lead_valid = 1'b0, trail_valid = 1'b0;
  logic [31:0] lead_addr = '0, trail_addr = '0;
  logic        lead_ready, lead_rsp_valid, mem_req, trail_ready, fault;
  logic [31:0] lead_rsp_data, mem_addr, trail_data;
  logic [31:0] mem_rdata = '0;
  logic [31:0] mem [64];
  logic [31:0] q_addr[$];
  logic [31:0] q_data[$];
  int tests = 0, fails = 0;

  always #2 clk = ~clk;

  load_replica_queue #(.DEPTH(DEPTH)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .lead_req_valid_i(lead_valid), .lead_req_ready_o(lead_ready),
    .lead_req_addr_i(lead_addr), .lead_rsp_valid_o(lead_rsp_valid),
    .lead_rsp_data_o(lead_rsp_data), .mem_req_o(mem_req),
    .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
    .trail_req_valid_i(trail_valid), .trail_req_ready_o(trail_ready),
    .trail_req_addr_i(trail_addr), .trail_rsp_data_o(trail_data),
    .fault_o(fault)
  );

  // memory model with one-cycle read latency
  always @(posedge clk) if (mem_req) mem_rdata <= mem[mem_addr[5:0]];

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  task automatic lead_load(input logic [31:0] a, input string req);
    logic [31:0] ed;
    @(negedge clk);
    lead_valid = 1'b1; lead_addr = a;
    while (!lead_ready) @(negedge clk);
    ed = mem[a[5:0]];
    q_addr.push_back(a); q_data.push_back(ed);
    @(negedge clk);
    lead_valid = 1'b0;
    chk(lead_rsp_valid == 1'b1, req, 32'(lead_rsp_valid), 32'd1);
    chk(lead_rsp_data == ed, req, lead_rsp_data, ed);
  endtask

  task automatic trail_load(input bit mism, input string req);
    logic [31:0] ea, ed;
    ea = q_addr.pop_front(); ed = q_data.pop_front();
    @(negedge clk);
    trail_valid = 1'b1; trail_addr = mism ? (ea ^ 32'h4) : ea;
    while (!trail_ready) @(negedge clk);
    chk(trail_data == ed, req, trail_data, ed);
    @(negedge clk);
    trail_valid = 1'b0;
    chk(fault == mism, "R5", 32'(fault), 32'(mism));
    @(negedge clk);
    chk(fault == 1'b0, "R5", 32'(fault), 32'd0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(lead_ready == 1'b1, "R8", 32'(lead_ready), 32'd1);
    chk(trail_ready == 1'b0, "R8", 32'(trail_ready), 32'd0);
    chk(fault == 1'b0, "R8", 32'(fault), 32'd0);
    chk(mem_req == 1'b0, "R8", 32'(mem_req), 32'd0);
  endtask

  task automatic t_order();
    for (int i = 0; i < 4; i++) lead_load(32'(3 + 5 * i), "R1");
    for (int i = 0; i < 4; i++) trail_load(1'b0, "R3");
  endtask

  task automatic t_replicate();
    logic [31:0] old;
    old = mem[7];
    lead_load(32'd7, "R4");
    @(negedge clk) mem[7] = ~old;
    trail_load(1'b0, "R4");
    lead_load(32'd7, "R4");
    trail_load(1'b0, "R4");
  endtask

  task automatic t_mismatch();
    lead_load(32'd12, "R5");
    lead_load(32'd13, "R5");
    trail_load(1'b1, "R5");
    trail_load(1'b0, "R5");
  endtask

  task automatic t_empty();
    @(negedge clk);
    trail_valid = 1'b1; trail_addr = 32'd9;
    for (int i = 0; i < 3; i++) begin
      chk(trail_ready == 1'b0, "R7", 32'(trail_ready), 32'd0);
      chk(mem_req == 1'b0, "R2", 32'(mem_req), 32'd0);
      @(negedge clk);
    end
    trail_valid = 1'b0;
    chk(fault == 1'b0, "R7", 32'(fault), 32'd0);
    lead_load(32'd9, "R7");
    trail_load(1'b0, "R7");
  endtask

  task automatic t_full();
    int acc = 0;
    @(negedge clk);
    lead_valid = 1'b1;
    for (int i = 0; i < DEPTH + 3; i++) begin
      lead_addr = 32'(i);
      if (lead_ready) begin
        acc++;
        q_addr.push_back(32'(i)); q_data.push_back(mem[i]);
      end
      @(negedge clk);
    end
    lead_valid = 1'b0;
    chk(acc == DEPTH, "R6", 32'(acc), 32'(DEPTH));
    chk(lead_ready == 1'b0, "R6", 32'(lead_ready), 32'd0);
    trail_load(1'b0, "R6");
    chk(lead_ready == 1'b1, "R6", 32'(lead_ready), 32'd1);
    while (q_addr.size() > 0) trail_load(1'b0, "R6");
  endtask

  task automatic t_concurrent();
    lead_load(32'd40, "R9");
    lead_load(32'd41, "R9");
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(fault == 1'b0, "R9", 32'(fault), 32'd0);
      lead_valid = 1'b1; lead_addr = 32'(50 + i);
      trail_valid = 1'b1; trail_addr = q_addr[0];
      chk(lead_ready && trail_ready, "R9", 32'({lead_ready, trail_ready}), 32'd3);
      chk(trail_data == q_data[0], "R9", trail_data, q_data[0]);
      void'(q_addr.pop_front()); void'(q_data.pop_front());
      q_addr.push_back(32'(50 + i)); q_data.push_back(mem[50 + i]);
    end
    @(negedge clk);
    lead_valid = 1'b0; trail_valid = 1'b0;
    chk(fault == 1'b0, "R9", 32'(fault), 32'd0);
    while (q_addr.size() > 0) trail_load(1'b0, "R9");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'hC0DE_0000 ^ (32'(i) * 32'h0101_0357);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_order();
    t_replicate();
    t_mismatch();
    t_empty();
    t_full();
    t_concurrent();
    summary();
  end
endmodule